// File: doc/BRIEF.md
# Radar Chirp Timing Sequencer

This block sets the transmit and receive timing of a radar frame, counted in cycles of the 100 MHz processing clock. A frame has two halves. The first is a run of long chirps, and each long chirp is followed by its listen window. A guard interval comes next. The second half is a run of short chirps, and each short chirp also has its own listen window. The block drives a transmit-window flag and a receive-window flag. It also gives a flag that marks the short half of the frame, and the index of the chirp in progress. Two pulses mark the end of each chirp's listen window and the end of the whole frame.

The five durations (long chirp, long listen, guard, short chirp, short listen) come in on plain input ports. A load strobe captures them into a pending set. The pending set is copied into the working set only when a frame starts, so no window in a running frame ever changes length. The frame repeats on its own from reset onward.

Top module: `chirp_seq_top`

## Requirements
- R1: While `rst_n` is low, all output flags and pulses are 0 and `chirp_idx` is 0. On the first clock edge that samples `rst_n` high, the first long chirp begins.
- R2: Out of reset the durations are: long chirp 3000 cycles, long listen 13700 cycles, guard 17540 cycles, short chirp 50 cycles and short listen 17450 cycles.
- R3: A frame runs in this order. First come 16 long chirps, each made of its transmit window followed by its listen window. Then comes the guard interval, in which `chirp_active` and `listen_active` are both 0. Then come 16 short chirps, built the same way. `chirp_is_short` is 1 during the short transmit and listen windows, and 0 at all other times.
- R4: `chirp_active` and `listen_active` are never 1 together. Each transmit window is followed directly by its listen window.
- R5: `chirp_done` is a one-cycle pulse in the last cycle of every listen window, after long chirps and after short chirps alike. In the following cycle `listen_active` is 0.
- R6: `chirp_idx` is 0 for the first chirp of a frame and goes up by one in the cycle after each `chirp_done`. It reads 16 during the guard interval and 31 in the last short chirp, and it returns to 0 when a new frame starts. Its value does not change at any other time.
- R7: `frame_done` pulses for one cycle, in the same cycle as the `chirp_done` of the last short chirp. The next cycle is the first cycle of the next frame's first long chirp.
- R8: A cycle with `cfg_load` high captures all five duration inputs. The captured values take effect at the start of the next frame, and the frame in progress keeps its durations. A load in the `frame_done` cycle applies to the frame that begins on the next cycle.
- R9: A duration of zero, whether loaded or given as a default, is run as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz processing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Strobe that captures the five duration inputs |
| cfg_long_tx_len | input | 16 | Long chirp transmit length in cycles |
| cfg_long_rx_len | input | 16 | Listen length after a long chirp |
| cfg_guard_len | input | 16 | Guard interval length between the two halves |
| cfg_short_tx_len | input | 16 | Short chirp transmit length in cycles |
| cfg_short_rx_len | input | 16 | Listen length after a short chirp |
| chirp_active | output | 1 | High during any transmit window |
| listen_active | output | 1 | High during any listen window |
| chirp_is_short | output | 1 | High during short transmit and listen windows |
| chirp_idx | output | 5 | Index of the chirp in progress within the frame |
| chirp_done | output | 1 | Pulse in the last cycle of each listen window |
| frame_done | output | 1 | Pulse in the last cycle of the frame |

## Verification
The properties are checked only while `rst_n` is high. They do not depend on the duration values: every duration, including zero, is a legal input, and the checker holds for any value. The stimulus loads new durations only through `cfg_load`, and it places each load either in the middle of a frame or exactly on the `frame_done` cycle. As a result, every frame the bench observes has one known set of durations, which lets the bench predict each frame from its requirements. A second instance built with the stock defaults is watched only through its first long chirp, to keep the run short.

// File: rtl/chirp_seq_pkg.sv
// Package: shared indices and phase encoding for the chirp sequencer.
// Assumes: durations travel as a packed array indexed by the D_* constants.
package chirp_seq_pkg;

    localparam int N_DUR = 5;
    localparam int D_LTX = 0;
    localparam int D_LRX = 1;
    localparam int D_GRD = 2;
    localparam int D_STX = 3;
    localparam int D_SRX = 4;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LTX   = 3'd1,
        PH_LRX   = 3'd2,
        PH_GUARD = 3'd3,
        PH_STX   = 3'd4,
        PH_SRX   = 3'd5
    } phase_t;

endpackage

// File: rtl/chirp_seq_cfg.sv
// Module: duration registers. A load strobe fills a pending set, and the
// working set copies it at each frame boundary. Zero values are raised to one.
// Assumes: boundary is high for exactly the cycle before a frame starts.
module chirp_seq_cfg
    import chirp_seq_pkg::*;
#(
    parameter int DUR_W = 16,
    parameter logic [N_DUR-1:0][DUR_W-1:0] DEF_DUR = '0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic [N_DUR-1:0][DUR_W-1:0]     wr_dur,
    input  logic                            boundary,
    output logic [N_DUR-1:0][DUR_W-1:0]     act_dur,
    output logic [N_DUR-1:0][DUR_W-1:0]     nxt_dur
);

    for (genvar k = 0; k < N_DUR; k++) begin : g_fld
        localparam logic [DUR_W-1:0] DEF_EFF =
            (DEF_DUR[k] == '0) ? DUR_W'(1) : DEF_DUR[k];
        logic [DUR_W-1:0] pend_q;
        logic [DUR_W-1:0] act_q;
        logic [DUR_W-1:0] src;

        // Select the value a boundary in this cycle would adopt.
        assign src        = load ? wr_dur[k] : pend_q;
        assign nxt_dur[k] = (src == '0) ? DUR_W'(1) : src;
        assign act_dur[k] = act_q;

        // Capture host writes into the pending set.
        always_ff @(posedge clk) begin
            if (!rst_n)    pend_q <= DEF_DUR[k];
            else if (load) pend_q <= wr_dur[k];
        end

        // Adopt the pending value only at a frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)        act_q <= DEF_EFF;
            else if (boundary) act_q <= nxt_dur[k];
        end
    end

endmodule

// File: rtl/chirp_seq_timer.sv
// Module: down-counter that times one window. It expires when it reaches zero.
// Assumes: load_val is at least one, and load comes in the cycle of expiry.
module chirp_seq_timer #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DUR_W-1:0] load_val,
    output logic             expire
);

    logic [DUR_W-1:0] cnt_q;

    assign expire = (cnt_q == '0);

    // Reload for a new window, or count down toward expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val - DUR_W'(1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - DUR_W'(1);
    end

endmodule

// File: rtl/chirp_seq_fsm.sv
// Module: frame phase machine and chirp counter. It picks the next window's
// length and reports chirp and frame completion.
// Assumes: NUM_LONG and NUM_SHORT are at least one, and IDX_W covers their sum.
module chirp_seq_fsm
    import chirp_seq_pkg::*;
#(
    parameter int DUR_W     = 16,
    parameter int NUM_LONG  = 16,
    parameter int NUM_SHORT = 16,
    parameter int IDX_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        expire,
    input  logic [N_DUR-1:0][DUR_W-1:0] act_dur,
    input  logic [DUR_W-1:0]            nxt_long_tx,
    output phase_t                      phase,
    output logic                        timer_load,
    output logic [DUR_W-1:0]            timer_val,
    output logic [IDX_W-1:0]            chirp_idx,
    output logic                        chirp_done,
    output logic                        frame_done,
    output logic                        boundary
);

    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(NUM_LONG - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(NUM_LONG + NUM_SHORT - 1);

    phase_t           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q;

    assign phase      = phase_q;
    assign chirp_idx  = idx_q;
    assign timer_load = (phase_q == PH_IDLE) || expire;
    assign chirp_done = expire && ((phase_q == PH_LRX) || (phase_q == PH_SRX));
    assign frame_done = expire && (phase_q == PH_SRX) && (idx_q == LAST_SHORT);
    assign boundary   = (phase_q == PH_IDLE) || frame_done;

    // Choose the following phase and the length of its window.
    always_comb begin
        phase_d   = phase_q;
        timer_val = act_dur[D_LTX];
        unique case (phase_q)
            PH_IDLE: begin
                phase_d = PH_LTX;   timer_val = nxt_long_tx;
            end
            PH_LTX: begin
                phase_d = PH_LRX;   timer_val = act_dur[D_LRX];
            end
            PH_LRX: begin
                if (idx_q == LAST_LONG) begin
                    phase_d = PH_GUARD; timer_val = act_dur[D_GRD];
                end else begin
                    phase_d = PH_LTX;   timer_val = act_dur[D_LTX];
                end
            end
            PH_GUARD: begin
                phase_d = PH_STX;   timer_val = act_dur[D_STX];
            end
            PH_STX: begin
                phase_d = PH_SRX;   timer_val = act_dur[D_SRX];
            end
            PH_SRX: begin
                if (idx_q == LAST_SHORT) begin
                    phase_d = PH_LTX;   timer_val = nxt_long_tx;
                end else begin
                    phase_d = PH_STX;   timer_val = act_dur[D_STX];
                end
            end
            default: begin
                phase_d = PH_IDLE;  timer_val = act_dur[D_LTX];
            end
        endcase
    end

    // Advance the phase whenever the current window ends.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase_q <= PH_IDLE;
        else if (timer_load) phase_q <= phase_d;
    end

    // Count chirps in the frame and wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx_q <= '0;
        else if (frame_done) idx_q <= '0;
        else if (chirp_done) idx_q <= idx_q + IDX_W'(1);
    end

endmodule

// File: rtl/chirp_seq_top.sv
// Module: top of the chirp timing sequencer. It joins the duration registers,
// the window timer and the phase machine, and decodes the phase to flags.
// Assumes: a 100 MHz clock, so one duration count is 10 ns.
module chirp_seq_top
    import chirp_seq_pkg::*;
#(
    parameter int DUR_W        = 16,
    parameter int NUM_LONG     = 16,
    parameter int NUM_SHORT    = 16,
    parameter int DEF_LONG_TX  = 3000,
    parameter int DEF_LONG_RX  = 13700,
    parameter int DEF_GUARD    = 17540,
    parameter int DEF_SHORT_TX = 50,
    parameter int DEF_SHORT_RX = 17450,
    localparam int IDX_W       = $clog2(NUM_LONG + NUM_SHORT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [DUR_W-1:0] cfg_long_tx_len,
    input  logic [DUR_W-1:0] cfg_long_rx_len,
    input  logic [DUR_W-1:0] cfg_guard_len,
    input  logic [DUR_W-1:0] cfg_short_tx_len,
    input  logic [DUR_W-1:0] cfg_short_rx_len,
    output logic             chirp_active,
    output logic             listen_active,
    output logic             chirp_is_short,
    output logic [IDX_W-1:0] chirp_idx,
    output logic             chirp_done,
    output logic             frame_done
);

    localparam logic [N_DUR-1:0][DUR_W-1:0] DEF_DUR = {
        DUR_W'(DEF_SHORT_RX), DUR_W'(DEF_SHORT_TX), DUR_W'(DEF_GUARD),
        DUR_W'(DEF_LONG_RX),  DUR_W'(DEF_LONG_TX)
    };

    logic [N_DUR-1:0][DUR_W-1:0] wr_dur, act_dur, nxt_dur;
    logic                        boundary, timer_load, expire;
    logic [DUR_W-1:0]            timer_val;
    phase_t                      phase;

    assign wr_dur = {cfg_short_rx_len, cfg_short_tx_len, cfg_guard_len,
                     cfg_long_rx_len, cfg_long_tx_len};

    chirp_seq_cfg #(.DUR_W(DUR_W), .DEF_DUR(DEF_DUR)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .wr_dur   (wr_dur),
        .boundary (boundary),
        .act_dur  (act_dur),
        .nxt_dur  (nxt_dur)
    );

    chirp_seq_timer #(.DUR_W(DUR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expire   (expire)
    );

    chirp_seq_fsm #(
        .DUR_W(DUR_W), .NUM_LONG(NUM_LONG),
        .NUM_SHORT(NUM_SHORT), .IDX_W(IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .act_dur     (act_dur),
        .nxt_long_tx (nxt_dur[D_LTX]),
        .phase       (phase),
        .timer_load  (timer_load),
        .timer_val   (timer_val),
        .chirp_idx   (chirp_idx),
        .chirp_done  (chirp_done),
        .frame_done  (frame_done),
        .boundary    (boundary)
    );

    // Decode the phase into the window flags.
    always_comb begin
        chirp_active   = (phase == PH_LTX) || (phase == PH_STX);
        listen_active  = (phase == PH_LRX) || (phase == PH_SRX);
        chirp_is_short = (phase == PH_STX) || (phase == PH_SRX);
    end

endmodule

// File: rtl/chirp_seq_checker.sv
// Module: protocol properties of the sequencer outputs, bound to the top.
// Assumes: properties hold only while rst_n is high.
module chirp_seq_checker #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chirp_active,
    input logic             listen_active,
    input logic             chirp_is_short,
    input logic [IDX_W-1:0] chirp_idx,
    input logic             chirp_done,
    input logic             frame_done
);

    p_tx_rx_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(chirp_active && listen_active));

    p_tx_then_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chirp_active) |-> listen_active);

    p_done_in_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_done |-> listen_active);

    p_done_ends_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_done |=> !listen_active);

    p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chirp_done && !frame_done) |=> chirp_idx == IDX_W'($past(chirp_idx) + 1'b1));

    p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !chirp_done |=> $stable(chirp_idx));

    p_frame_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (chirp_done && chirp_is_short));

    p_frame_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (chirp_active && !chirp_is_short && chirp_idx == '0));

endmodule

bind chirp_seq_top chirp_seq_checker #(.IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .chirp_active   (chirp_active),
    .listen_active  (listen_active),
    .chirp_is_short (chirp_is_short),
    .chirp_idx      (chirp_idx),
    .chirp_done     (chirp_done),
    .frame_done     (frame_done)
);

// File: tb/chirp_seq_top_bench.sv
module chirp_seq_top_bench;

    localparam int DW = 16;
    localparam int IW = 5;
    localparam int NL = 16;
    localparam int NS = 16;
    // Small start-up durations for the main instance
    localparam int S_LT = 5, S_LR = 7, S_G = 9, S_ST = 2, S_SR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [DW-1:0] c_lt = '0, c_lr = '0, c_g = '0, c_st = '0, c_sr = '0;

    logic ca, la, sh, cd, fd;
    logic [IW-1:0] idx;
    logic d_ca, d_la, d_sh, d_cd, d_fd;
    logic [IW-1:0] d_idx;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    chirp_seq_top #(
        .DEF_LONG_TX(S_LT), .DEF_LONG_RX(S_LR), .DEF_GUARD(S_G),
        .DEF_SHORT_TX(S_ST), .DEF_SHORT_RX(S_SR)
    ) u_chirp_seq_top (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_long_tx_len(c_lt), .cfg_long_rx_len(c_lr), .cfg_guard_len(c_g),
        .cfg_short_tx_len(c_st), .cfg_short_rx_len(c_sr),
        .chirp_active(ca), .listen_active(la), .chirp_is_short(sh),
        .chirp_idx(idx), .chirp_done(cd), .frame_done(fd)
    );

    chirp_seq_top u_chirp_seq_top_dflt (
        .clk(clk), .rst_n(rst_n), .cfg_load(1'b0),
        .cfg_long_tx_len('0), .cfg_long_rx_len('0), .cfg_guard_len('0),
        .cfg_short_tx_len('0), .cfg_short_rx_len('0),
        .chirp_active(d_ca), .listen_active(d_la), .chirp_is_short(d_sh),
        .chirp_idx(d_idx), .chirp_done(d_cd), .frame_done(d_fd)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int frame_len(int lt, int lr, int g, int st, int sr);
        return NL * (eff(lt) + eff(lr)) + eff(g) + NS * (eff(st) + eff(sr));
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare the main instance flags {ca,la,sh,cd,fd,idx} with expectation
    task automatic chk_cyc(string req, int cyc, logic eca, logic ela, logic esh,
                           logic ecd, logic efd, int eidx);
        logic [IW+4:0] a, e;
        a = {ca, la, sh, cd, fd, idx};
        e = {eca, ela, esh, ecd, efd, IW'(eidx)};
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s cycle %0d {tx,rx,short,done,fdone,idx}: actual=%h expected=%h",
                     req, cyc, a, e);
        end
    endtask

    // Walk one full frame from its first cycle, predicting every cycle
    task automatic walk_frame(int lt, int lr, int g, int st, int sr, string req);
        int cyc = 0;
        for (int i = 0; i < NL; i++) begin
            for (int c = 0; c < eff(lt); c++) begin
                chk_cyc(req, cyc, 1, 0, 0, 0, 0, i); step(); cyc++;
            end
            for (int c = 0; c < eff(lr); c++) begin
                chk_cyc(req, cyc, 0, 1, 0, c == eff(lr) - 1, 0, i); step(); cyc++;
            end
        end
        for (int c = 0; c < eff(g); c++) begin
            chk_cyc(req, cyc, 0, 0, 0, 0, 0, NL); step(); cyc++;
        end
        for (int i = NL; i < NL + NS; i++) begin
            for (int c = 0; c < eff(st); c++) begin
                chk_cyc(req, cyc, 1, 0, 1, 0, 0, i); step(); cyc++;
            end
            for (int c = 0; c < eff(sr); c++) begin
                chk_cyc(req, cyc, 0, 1, 1, c == eff(sr) - 1,
                        (c == eff(sr) - 1) && (i == NL + NS - 1), i);
                step(); cyc++;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_load = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic drive_cfg(int lt, int lr, int g, int st, int sr);
        c_lt = DW'(lt); c_lr = DW'(lr); c_g = DW'(g); c_st = DW'(st); c_sr = DW'(sr);
    endtask

    // R1: idle outputs during reset, first long chirp right after release
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R1", "reset tx/rx/short", {ca, la, sh}, 0);
        chk("R1", "reset done pulses", {cd, fd}, 0);
        chk("R1", "reset idx", idx, 0);
        chk("R1", "reset default-instance flags", {d_ca, d_la, d_sh, d_cd, d_fd}, 0);
        rst_n = 1'b1;
        step();
        chk("R1", "first cycle tx", ca, 1);
        chk("R1", "first cycle idx", idx, 0);
    endtask

    // R2: stock durations seen on the default-parameter instance
    task automatic t_defaults();
        do_reset();
        for (int c = 0; c <= 16700; c++) begin
            if (c == 0 || c == 2999) chk("R2", "long tx held", {d_ca, d_la}, 2'b10);
            if (c == 3000)  chk("R2", "long tx ends after 3000", {d_ca, d_la}, 2'b01);
            if (c == 16698) chk("R2", "long listen not done yet", d_cd, 0);
            if (c == 16699) chk("R2", "long listen ends after 13700", {d_la, d_cd}, 2'b11);
            if (c == 16700) chk("R2", "second chirp starts", {d_ca, 27'(d_idx)}, {1'b1, 27'd1});
            step();
        end
    endtask

    // R3 R5 R6 R7: two consecutive frames with start-up durations
    task automatic t_frames();
        do_reset();
        walk_frame(S_LT, S_LR, S_G, S_ST, S_SR, "R3 R5 R6 R7 frame1");
        walk_frame(S_LT, S_LR, S_G, S_ST, S_SR, "R3 R6 R7 frame2");
    endtask

    // R8: mid-frame load deferred; load on the frame_done cycle applies next
    task automatic t_load();
        fork
            walk_frame(S_LT, S_LR, S_G, S_ST, S_SR, "R8 unchanged mid-frame");
            begin
                repeat (40) step();
                drive_cfg(8, 3, 6, 1, 5);
                cfg_load = 1'b1;
                step();
                cfg_load = 1'b0;
                drive_cfg(0, 0, 0, 0, 0);
            end
        join
        fork
            walk_frame(8, 3, 6, 1, 5, "R8 new values next frame");
            begin
                repeat (frame_len(8, 3, 6, 1, 5) - 1) step();
                drive_cfg(3, 4, 2, 3, 2);
                cfg_load = 1'b1;
                step();
                cfg_load = 1'b0;
            end
        join
        walk_frame(3, 4, 2, 3, 2, "R8 load on frame_done cycle");
    endtask

    // R9: zero durations run as one cycle each
    task automatic t_zero();
        fork
            walk_frame(3, 4, 2, 3, 2, "R9 before zero load");
            begin
                repeat (10) step();
                drive_cfg(0, 0, 0, 0, 0);
                cfg_load = 1'b1;
                step();
                cfg_load = 1'b0;
            end
        join
        walk_frame(0, 0, 0, 0, 0, "R9 R5 zero durations");
        walk_frame(0, 0, 0, 0, 0, "R9 R7 zero frame repeat");
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        #1;
        t_reset();
        t_defaults();
        t_frames();
        t_load();
        t_zero();
        finish_run();
    end

endmodule